// File: doc/BRIEF.md
# LED Serial Shift-Chain Sequencer

This block drives a chain of external serial-in, parallel-out shift registers that light status LEDs. It turns one refresh into a serial frame: one data bit goes out per LED-clock falling-edge strobe from a separate timebase. After the last bit, a latch pulse tells the external registers to copy their contents to the LEDs. Frames repeat back to back for as long as the interface is enabled.

A frame is built from four segments, and each one can be present or absent:

- a user header of 0 to 32 bits;
- a status field for each enabled port, with up to 8 ports and up to 6 bits per port;
- an optional 17-bit debug word;
- a user trailer of 0 to 32 bits.

The longest possible frame is therefore 129 bits. The per-port fields are formatted upstream and arrive as a bit vector plus a length for each port. The sequencer captures the whole frame at the start of a refresh, so configuration writes made during a frame have no effect on that frame. An output polarity control inverts the data so that active-low LEDs can be used.

Top module: `led_chain_seq`

## Requirements
- R1: A frame carries the header, then the enabled port fields, then the debug word, then the trailer. Every segment is sent bit 0 first: header bit i is `hdr_dat[i]`, port p bit b is `port_bits[6p+b]`, debug bit d is `dbg_word[d]`, and trailer bit i is `trl_dat[i]`.
- R2: The header sends `hdr_len` bits and the trailer sends `trl_len` bits. A length of 0 omits the segment, and any length above 32 is treated as 32.
- R3: Ports are sent in ascending port number order. A port whose `port_en[p]` bit is 0 sends nothing. An enabled port sends `port_len[3p+2:3p]` bits, and a length above 6 is treated as 6.
- R4: When `dbg_en` is 1, the frame holds all 17 debug bits. When `dbg_en` is 0, the debug segment is absent.
- R5: Each frame uses these strobes in order: one load strobe, then one strobe per frame bit, then one latch strobe. On every strobe, the outputs update on the next clock edge. Between strobes, the outputs do not change.
- R6: On the latch strobe, `latch` rises. It stays high for exactly one strobe interval and is cleared by the next strobe, which is also the load strobe of the next frame. While `latch` is high, `ser_dat` holds the last bit of the frame. A frame of zero bits still produces its latch pulse.
- R7: `ser_dat` equals the logical frame bit XOR `invert`. A change to `invert` takes effect immediately, at any point in a frame.
- R8: The frame content and its length are captured on the load strobe. Input changes after that point first appear in the next frame. `frame_bits` reports the captured length.
- R9: While `chain_en` is 0, the clock edge after the enable drops returns the block to idle: `latch` = 0, `frame_bits` = 0, and the logical data is 0, so `ser_dat` = `invert`. The next frame then begins on the first strobe after the enable is set again.
- R10: After a synchronous active-low reset, the block is in the same idle state as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_stb | input | 1 | One-cycle strobe marking each LED-clock falling edge |
| chain_en | input | 1 | Runs the chain when 1 |
| invert | input | 1 | 1 inverts the serial data for active-low LEDs |
| hdr_dat | input | 32 | Header bits |
| hdr_len | input | 6 | Header bit count (clamped to 32) |
| trl_dat | input | 32 | Trailer bits |
| trl_len | input | 6 | Trailer bit count (clamped to 32) |
| port_en | input | 8 | Per-port enable |
| port_bits | input | 48 | Formatted port fields, 6 bits per port |
| port_len | input | 24 | Port field lengths, 3 bits per port (clamped to 6) |
| dbg_en | input | 1 | Inserts the debug word when 1 |
| dbg_word | input | 17 | Debug bits |
| ser_dat | output | 1 | Serial data to the shift chain |
| frame_bits | output | 8 | Bit count of the current frame |
| latch | output | 1 | Latch pulse after the last bit |

## Verification
Two events can fall on the same strobe: the end of one latch pulse and the load of the next frame. An enable drop can also arrive on the same clock as a strobe. The bench provokes the first case by running back-to-back frames with a strobe on every clock and with zero-length frames, so that latch clearing and frame capture coincide repeatedly. It provokes the second case by dropping `chain_en` on a strobe cycle in the middle of a frame. The bench judges both cases against a behavioural queue model that rebuilds each frame from the requirements and compares the serial data, the latch and the frame length on every clock.

// File: rtl/led_chain_pkg.sv
// Shared constants and the sequencer state type for the LED shift chain.
package led_chain_pkg;
    localparam int DEF_PORTS  = 8;   // number of status ports
    localparam int DEF_PORT_W = 6;   // widest per-port field
    localparam int DEF_UDD_W  = 32;  // header / trailer data width
    localparam int DEF_DBG_W  = 17;  // debug word width

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_LATCH = 2'd2
    } seq_st_e;
endpackage

// File: rtl/led_frame_pack.sv
// Frame packer: concatenates header, enabled port fields, debug word and
// trailer into one LSB-first vector and reports the total bit count.
// Assumes: lengths are clamped here; the result is purely combinational.
module led_frame_pack #(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 6,
    parameter int UDD_W     = 32,
    parameter int DBG_W     = 17,
    parameter int CNT_W     = $clog2(UDD_W + 1),
    parameter int PL_W      = $clog2(PORT_W + 1),
    parameter int MAX_BITS  = 2 * UDD_W + NUM_PORTS * PORT_W + DBG_W,
    parameter int LEN_W     = $clog2(MAX_BITS + 1)
) (
    input  logic [UDD_W-1:0]            hdr_dat,
    input  logic [CNT_W-1:0]            hdr_len,
    input  logic [UDD_W-1:0]            trl_dat,
    input  logic [CNT_W-1:0]            trl_len,
    input  logic [NUM_PORTS-1:0]        port_en,
    input  logic [NUM_PORTS*PORT_W-1:0] port_bits,
    input  logic [NUM_PORTS*PL_W-1:0]   port_len,
    input  logic                        dbg_en,
    input  logic [DBG_W-1:0]            dbg_word,
    output logic [MAX_BITS-1:0]         frame_vec,
    output logic [LEN_W-1:0]            frame_len
);
    logic [CNT_W-1:0] hl_c, tl_c;
    logic [PL_W-1:0]  pl_c [NUM_PORTS];

    // Clamp header and trailer counts to the data width.
    assign hl_c = (hdr_len > CNT_W'(UDD_W)) ? CNT_W'(UDD_W) : hdr_len;
    assign tl_c = (trl_len > CNT_W'(UDD_W)) ? CNT_W'(UDD_W) : trl_len;

    // Clamp each port field length to the port field width.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pclamp
        logic [PL_W-1:0] raw;
        assign raw     = port_len[p*PL_W +: PL_W];
        assign pl_c[p] = (raw > PL_W'(PORT_W)) ? PL_W'(PORT_W) : raw;
    end

    // Pack the segments in frame order, advancing a write position.
    always_comb begin
        logic [LEN_W-1:0] pos;
        frame_vec = '0;
        pos       = '0;
        for (int i = 0; i < UDD_W; i++) begin
            if (i < int'(hl_c)) begin
                frame_vec[pos] = hdr_dat[i];
                pos = pos + LEN_W'(1);
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int b = 0; b < PORT_W; b++) begin
                if (port_en[p] && (b < int'(pl_c[p]))) begin
                    frame_vec[pos] = port_bits[p*PORT_W + b];
                    pos = pos + LEN_W'(1);
                end
            end
        end
        for (int d = 0; d < DBG_W; d++) begin
            if (dbg_en) begin
                frame_vec[pos] = dbg_word[d];
                pos = pos + LEN_W'(1);
            end
        end
        for (int i = 0; i < UDD_W; i++) begin
            if (i < int'(tl_c)) begin
                frame_vec[pos] = trl_dat[i];
                pos = pos + LEN_W'(1);
            end
        end
        frame_len = pos;
    end
endmodule

// File: rtl/led_bit_shift.sv
// Strobe-paced sequencer: captures a packed frame on the load strobe,
// emits one bit per strobe, then raises the latch for one strobe interval.
// Assumes: fall_stb is a single-cycle pulse; chain_en low forces idle.
module led_bit_shift
    import led_chain_pkg::*;
#(
    parameter int MAX_BITS = 129,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_stb,
    input  logic                chain_en,
    input  logic [MAX_BITS-1:0] frame_vec,
    input  logic [LEN_W-1:0]    frame_len,
    output logic                bit_q,
    output logic                latch_q,
    output logic [LEN_W-1:0]    flen_q
);
    seq_st_e             st_q;
    logic [MAX_BITS-1:0] snap_q;
    logic [LEN_W-1:0]    idx_q;

    // Advance the frame state machine on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !chain_en) begin
            st_q    <= SQ_IDLE;
            snap_q  <= '0;
            idx_q   <= '0;
            flen_q  <= '0;
            bit_q   <= 1'b0;
            latch_q <= 1'b0;
        end else if (fall_stb) begin
            case (st_q)
                SQ_IDLE: begin
                    latch_q <= 1'b0;
                    bit_q   <= 1'b0;
                    snap_q  <= frame_vec;
                    flen_q  <= frame_len;
                    idx_q   <= '0;
                    st_q    <= (frame_len == '0) ? SQ_LATCH : SQ_SHIFT;
                end
                SQ_SHIFT: begin
                    bit_q <= snap_q[idx_q];
                    idx_q <= idx_q + LEN_W'(1);
                    if (idx_q == flen_q - LEN_W'(1)) st_q <= SQ_LATCH;
                end
                SQ_LATCH: begin
                    latch_q <= 1'b1;
                    st_q    <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/led_chain_seq.sv
// Top: LED serial shift-chain sequencer. Packs a variable-length frame and
// serializes it against the falling-edge strobe, with output polarity.
// Assumes: port fields arrive pre-formatted; strobes come from a timebase.
module led_chain_seq
    import led_chain_pkg::*;
#(
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int PORT_W    = DEF_PORT_W,
    parameter int UDD_W     = DEF_UDD_W,
    parameter int DBG_W     = DEF_DBG_W,
    parameter int CNT_W     = $clog2(UDD_W + 1),
    parameter int PL_W      = $clog2(PORT_W + 1),
    parameter int MAX_BITS  = 2 * UDD_W + NUM_PORTS * PORT_W + DBG_W,
    parameter int LEN_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fall_stb,
    input  logic                        chain_en,
    input  logic                        invert,
    input  logic [UDD_W-1:0]            hdr_dat,
    input  logic [CNT_W-1:0]            hdr_len,
    input  logic [UDD_W-1:0]            trl_dat,
    input  logic [CNT_W-1:0]            trl_len,
    input  logic [NUM_PORTS-1:0]        port_en,
    input  logic [NUM_PORTS*PORT_W-1:0] port_bits,
    input  logic [NUM_PORTS*PL_W-1:0]   port_len,
    input  logic                        dbg_en,
    input  logic [DBG_W-1:0]            dbg_word,
    output logic                        ser_dat,
    output logic [LEN_W-1:0]            frame_bits,
    output logic                        latch
);
    logic [MAX_BITS-1:0] pk_vec;
    logic [LEN_W-1:0]    pk_len;
    logic                bit_q;

    led_frame_pack #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .UDD_W(UDD_W), .DBG_W(DBG_W),
        .CNT_W(CNT_W), .PL_W(PL_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
    ) u_pack (
        .hdr_dat(hdr_dat), .hdr_len(hdr_len), .trl_dat(trl_dat), .trl_len(trl_len),
        .port_en(port_en), .port_bits(port_bits), .port_len(port_len),
        .dbg_en(dbg_en), .dbg_word(dbg_word),
        .frame_vec(pk_vec), .frame_len(pk_len)
    );

    led_bit_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .chain_en(chain_en),
        .frame_vec(pk_vec), .frame_len(pk_len),
        .bit_q(bit_q), .latch_q(latch), .flen_q(frame_bits)
    );

    // Apply the LED polarity live to the logical data bit.
    assign ser_dat = bit_q ^ invert;
endmodule

// File: rtl/led_chain_chk.sv
// Checker for led_chain_seq: port-level timing and polarity properties.
module led_chain_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fall_stb,
    input logic             chain_en,
    input logic             invert,
    input logic             ser_dat,
    input logic [LEN_W-1:0] frame_bits,
    input logic             latch
);
    AST_HOLD_BETWEEN_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chain_en) && chain_en && !$past(fall_stb) && $stable(invert))
        |-> ($stable(ser_dat) && $stable(latch) && $stable(frame_bits))); // R5

    AST_LATCH_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && fall_stb && latch) |=> !latch); // R6

    AST_POLARITY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chain_en) && chain_en && !$past(fall_stb) && !$stable(invert))
        |-> !$stable(ser_dat)); // R7

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |=> (!latch && frame_bits == '0 && ser_dat == invert)); // R9
endmodule

bind led_chain_seq led_chain_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .chain_en(chain_en),
    .invert(invert), .ser_dat(ser_dat), .frame_bits(frame_bits), .latch(latch)
);

// File: tb/sim_led_chain_seq.sv
// Bench: behavioural queue model of the LED frame, compared on every clock.
module sim_led_chain_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fall_stb = 1'b0;
    logic        chain_en = 1'b0;
    logic        invert = 1'b0;
    logic [31:0] hdr_dat = '0;
    logic [5:0]  hdr_len = '0;
    logic [31:0] trl_dat = '0;
    logic [5:0]  trl_len = '0;
    logic [7:0]  port_en = '0;
    logic [47:0] port_bits = '0;
    logic [23:0] port_len = '0;
    logic        dbg_en = 1'b0;
    logic [16:0] dbg_word = '0;
    logic        ser_dat;
    logic [7:0]  frame_bits;
    logic        latch;

    int    vectors = 0;
    int    miscompares = 0;
    int    stb_cnt = 0;
    bit    done = 1'b0;
    string req = "R10";

    // Reference model state
    int m_st = 0;
    bit m_q[$];
    int m_len = 0;
    bit m_bit = 1'b0;
    bit m_latch = 1'b0;

    always #2 clk = ~clk;

    led_chain_seq u0 (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .chain_en(chain_en),
        .invert(invert), .hdr_dat(hdr_dat), .hdr_len(hdr_len),
        .trl_dat(trl_dat), .trl_len(trl_len), .port_en(port_en),
        .port_bits(port_bits), .port_len(port_len), .dbg_en(dbg_en),
        .dbg_word(dbg_word), .ser_dat(ser_dat), .frame_bits(frame_bits),
        .latch(latch)
    );

    // Build the expected frame from the requirements (R1..R4).
    task automatic build_frame();
        int hl, tl, pl;
        m_q.delete();
        hl = (hdr_len > 32) ? 32 : int'(hdr_len);
        tl = (trl_len > 32) ? 32 : int'(trl_len);
        for (int i = 0; i < hl; i++) m_q.push_back(hdr_dat[i]);
        for (int p = 0; p < 8; p++) begin
            pl = int'(port_len[p*3 +: 3]);
            if (pl > 6) pl = 6;
            if (port_en[p]) for (int b = 0; b < pl; b++) m_q.push_back(port_bits[p*6 + b]);
        end
        if (dbg_en) for (int d = 0; d < 17; d++) m_q.push_back(dbg_word[d]);
        for (int i = 0; i < tl; i++) m_q.push_back(trl_dat[i]);
    endtask

    // Model update at each clock edge from the stable bench inputs.
    always @(posedge clk) begin
        if (!rst_n || !chain_en) begin
            m_st = 0; m_len = 0; m_bit = 0; m_latch = 0; m_q.delete();
        end else if (fall_stb) begin
            case (m_st)
                0: begin
                    m_latch = 0; m_bit = 0;
                    build_frame();
                    m_len = m_q.size();
                    m_st  = (m_len == 0) ? 2 : 1;
                end
                1: begin
                    m_bit = m_q.pop_front();
                    if (m_q.size() == 0) m_st = 2;
                end
                default: begin
                    m_latch = 1; m_st = 0;
                end
            endcase
        end
    end

    task automatic check();
        bit exp_ser;
        exp_ser = m_bit ^ invert;
        vectors++;
        if (ser_dat !== exp_ser) begin
            miscompares++;
            $display("FAIL %s ser_dat actual=%0b expected=%0b t=%0t", req, ser_dat, exp_ser, $time);
        end
        if (latch !== m_latch) begin
            miscompares++;
            $display("FAIL %s latch actual=%0b expected=%0b t=%0t", req, latch, m_latch, $time);
        end
        if (frame_bits !== 8'(m_len)) begin
            miscompares++;
            $display("FAIL %s frame_bits actual=%0d expected=%0d t=%0t", req, frame_bits, m_len, $time);
        end
    endtask

    // Run n cycles with a strobe every gap cycles, checking each cycle.
    task automatic run(int n, int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check();
            fall_stb = (stb_cnt == 0);
            stb_cnt  = (stb_cnt >= gap - 1) ? 0 : stb_cnt + 1;
        end
    endtask

    task automatic rand_cfg();
        hdr_dat   = $urandom; trl_dat = $urandom;
        port_bits = {$urandom, $urandom};
        dbg_word  = 17'($urandom);
    endtask

    initial begin
        // R10: reset state with enable asserted
        chain_en = 1'b1;
        req = "R10";
        run(6, 2);
        rst_n = 1'b1;

        // R1: all four segments, mixed port lengths
        req = "R1";
        rand_cfg();
        hdr_len = 6'd5; trl_len = 6'd7; dbg_en = 1'b1;
        port_en = 8'b0000_0101; port_len = {15'd0, 3'd6, 3'd0, 3'd3};
        run(600, 3);

        // R2: header clamp above 32, empty trailer
        req = "R2";
        rand_cfg();
        hdr_len = 6'd40; trl_len = 6'd0; dbg_en = 1'b0; port_en = '0;
        run(300, 2);
        trl_len = 6'd63; hdr_len = 6'd32;
        run(400, 2);

        // R3: ports 0 and 7, length clamp 7 -> 6
        req = "R3";
        rand_cfg();
        hdr_len = 6'd1; trl_len = 6'd1; port_en = 8'h81;
        port_len = {3'd7, 15'd0, 3'd7, 3'd2};
        run(200, 2);
        port_en = 8'hFF; port_len = {8{3'd5}};
        run(300, 2);

        // R4: debug segment removed
        req = "R4";
        dbg_en = 1'b0; port_en = 8'h02; hdr_len = 6'd3; trl_len = 6'd2;
        run(200, 2);
        dbg_en = 1'b1;
        run(200, 2);

        // R7: polarity flipped mid frame and between strobes
        req = "R7";
        hdr_len = 6'd20;
        run(37, 5);
        invert = 1'b1;
        run(41, 5);
        invert = 1'b0;
        run(23, 5);
        invert = 1'b1;
        run(200, 5);

        // R8: configuration rewritten while a frame is shifting
        req = "R8";
        rand_cfg();
        run(30, 3);
        hdr_dat = ~hdr_dat; port_en = 8'h3C; hdr_len = 6'd9; dbg_en = 1'b0;
        run(20, 3);
        trl_dat = $urandom; trl_len = 6'd12;
        run(400, 3);

        // R6: zero-length frames, strobe every clock (latch end meets load)
        req = "R6";
        hdr_len = '0; trl_len = '0; port_en = '0; dbg_en = 1'b0;
        run(40, 1);
        hdr_len = 6'd2;
        run(40, 1);

        // R5: dense and sparse strobe spacing
        req = "R5";
        rand_cfg();
        hdr_len = 6'd32; trl_len = 6'd32; port_en = 8'hFF; port_len = {8{3'd6}}; dbg_en = 1'b1;
        run(300, 1);
        run(1500, 7);

        // R9: enable dropped on a strobe cycle mid frame, then re-enabled
        req = "R9";
        run(25, 1);
        chain_en = 1'b0;
        run(10, 1);
        chain_en = 1'b1;
        run(200, 1);
        run(13, 4);
        chain_en = 1'b0;
        run(9, 4);
        chain_en = 1'b1;
        run(400, 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            miscompares++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule